// File: doc/BRIEF.md
# Phase-Shifted Carrier Modulator for a Nine-Level Two-Cell Inverter

This block drives the gates of two series-connected five-level H-bridge cells. Each cell has the usual four bridge switches plus a bidirectional switch to its capacitor midpoint. Every clock cycle the block does the following:

- It compares a held, signed reference sample against one triangular carrier per cell.
- It picks a level from -2 to +2 for each cell.
- It decodes that level into the cell's five gate signals.
- It reports the sum of the cell levels, which takes one of nine values from -4 to +4.

The reference is first reduced to a magnitude in carrier units. Inside the inner half of full scale, a cell toggles between zero and the half level. Outside it, the cell toggles between the half and full levels, and the carrier is compared against the part of the magnitude above one carrier amplitude. Every cell sees the same reference. The carriers share one programmable half-period and are spread evenly in phase, so two cells sit 180 degrees apart.

The zero level is produced with the switch pair that keeps the polarity switch of the current half-cycle steady. As a result, the two polarity switches only change when the reference changes sign. An enable input parks every cell at zero while the carriers keep running.

Top module: `nine_level_pwm`

## Requirements
- R1: Gate bit k-1 drives switch Sk of a cell (bit0=S1 .. bit4=S5), and cell c uses gate_o[5c+4:5c]. The level-to-gate mapping is:
  - +2 gives 01001.
  - +1 gives 11000.
  - -1 gives 10010.
  - -2 gives 00110.
  - Exactly two gates of a cell are on at any time.
- R2: Level 0 gives 00011 (S1,S2) when the block is enabled and the held reference is zero or negative. Otherwise level 0 gives 01100 (S3,S4). So S4 stays on through a whole positive half-cycle and S2 through a whole negative one.
- R3: ref_i is captured only in a cycle where ref_vld_i is high. A capture reaches the levels on the third rising edge after the strobe edge, counting the strobe edge as the first. Without a strobe, the levels keep following the previously captured sample.
- R4: The magnitude is computed as follows:
  - Take the absolute value of the held sample, with -32768 treated as 32767.
  - The magnitude in carrier units is m = floor(|ref|*H/16384), where H is car_half_i.
  - A positive sample is in the inner region when m <= H.
  - A zero or negative sample is in the inner region when m < H.
  - In the outer region the residue is r = m - H. In the inner region r = m.
- R5: Let r be the residue and c the cell's carrier value. The cell level is chosen as follows:
  - Positive inner: +1 when r > c, else 0.
  - Positive outer: +2 when r > c, else +1.
  - Negative inner (zero included): -1 when r > c, else 0.
  - Negative outer: -2 when r > c, else -1.
- R6: Each carrier is a triangle that steps by one per clock, going 0,1,..,H,H-1,..,1,0 with a period of 2H. After reset, cell 0 starts at 0 and rising. Cell k starts at phase k*2H/N along the triangle, so for two cells, cell 1 starts at H and falling. The level registered on an edge uses the carrier value from before that edge.
- R7: cell_lvl_o holds cell c's level in two's complement in bits [3c+2:3c]. sum_o equals the sum of the cell levels in the same cycle, with a range of -4..+4.
- R8: When en_i is low at an edge, every cell is at level 0 with gates 01100 after that edge. The carriers keep running, and when en_i returns, modulation resumes on the unchanged carrier timeline.
- R9: While rst is high, all levels and the sum are 0, every cell's gates are 01100, and the captured reference is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Modulation enable; low forces level 0 |
| ref_vld_i | input | 1 | Strobe that captures ref_i |
| ref_i | input | 16 | Signed reference sample, full scale ±32767 |
| car_half_i | input | 12 | Carrier half-period H (peak value), at least 2 |
| cell_lvl_o | output | 6 | Per-cell signed level, 3 bits per cell |
| gate_o | output | 10 | Per-cell gates, 5 bits per cell, S1 in the low bit |
| sum_o | output | 4 | Signed sum of the cell levels |

## Verification
Two events can land on the same edge: the enable falling and a reference strobe arriving that moves the sample from the positive outer region into the negative half. The bench issues both from the same clock low phase. It then expects the forced-zero code 01100 on every cell for as long as the enable stays low, even after the new sample has passed through the scaler. Once the enable returns, it expects the negative-half levels and gates, compared edge by edge against a carrier timeline the bench counts itself from reset.

// File: rtl/nlp_pkg.sv
package nlp_pkg;

  localparam int LVL_W  = 3;
  localparam int GATE_W = 5;

  typedef logic signed [LVL_W-1:0] lvl_t;
  typedef logic [GATE_W-1:0]       gate_t;

  // bit0 = S1 .. bit4 = S5
  localparam gate_t G_POS2   = 5'b01001;
  localparam gate_t G_POS1   = 5'b11000;
  localparam gate_t G_ZERO_P = 5'b01100;
  localparam gate_t G_ZERO_N = 5'b00011;
  localparam gate_t G_NEG1   = 5'b10010;
  localparam gate_t G_NEG2   = 5'b00110;

  function automatic gate_t lvl2gate(lvl_t lvl, logic neg_half);
    gate_t g;
    case (lvl)
      3'sd2:   g = G_POS2;
      3'sd1:   g = G_POS1;
      -3'sd1:  g = G_NEG1;
      -3'sd2:  g = G_NEG2;
      default: g = neg_half ? G_ZERO_N : G_ZERO_P;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/nlp_carrier.sv
module nlp_carrier #(
  parameter int CNT_W   = 12,
  parameter int N_CELLS = 2,
  parameter int IDX     = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] half_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam int PH_W = CNT_W + 2 + $clog2(N_CELLS + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             up_q;
  logic [PH_W-1:0]  two_h, half_x, phase;
  logic [CNT_W-1:0] pre_cnt;
  logic             pre_up;

  // reset preload: position IDX*2H/N along the triangle
  always_comb begin
    half_x = PH_W'(half_i);
    two_h  = half_x << 1;
    phase  = (PH_W'(IDX) * two_h) / PH_W'(N_CELLS);
    if (phase < half_x) begin
      pre_cnt = CNT_W'(phase);
      pre_up  = 1'b1;
    end else if (phase == half_x) begin
      pre_cnt = half_i;
      pre_up  = 1'b0;
    end else begin
      pre_cnt = CNT_W'(two_h - phase);
      pre_up  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= pre_cnt;
      up_q  <= pre_up;
    end else if (up_q) begin
      if (cnt_q >= half_i) begin
        cnt_q <= cnt_q - CNT_W'(1);
        up_q  <= 1'b0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
        if ((cnt_q + CNT_W'(1)) == half_i) up_q <= 1'b0;
      end
    end else begin
      if (cnt_q == '0) begin
        cnt_q <= CNT_W'(1);
        up_q  <= 1'b1;
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) up_q <= 1'b1;
      end
    end
  end

  assign cnt_o = cnt_q;

  // R6: an in-range carrier moves by exactly one step per clock
  a_r6_unit_step: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $stable(half_i) && (half_i >= CNT_W'(2)) && ($past(cnt_q) <= half_i))
      |-> ((cnt_q == $past(cnt_q) + CNT_W'(1)) || (cnt_q == $past(cnt_q) - CNT_W'(1))));

endmodule

// File: rtl/nlp_ref_scale.sv
module nlp_ref_scale #(
  parameter int REF_W = 16,
  parameter int CNT_W = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [REF_W-1:0] ref_i,
  input  logic [CNT_W-1:0]        half_i,
  output logic [CNT_W:0]          res_o,
  output logic                    neg_o,
  output logic                    outer_o
);

  localparam int ABS_W  = REF_W - 1;
  localparam int PROD_W = ABS_W + CNT_W;
  localparam int MAG_W  = CNT_W + 1;
  localparam int SHIFT  = REF_W - 2;

  logic [ABS_W-1:0]  mag_abs;
  logic [PROD_W-1:0] prod;
  logic [MAG_W-1:0]  mag, half_x, res_d;
  logic              neg_d, outer_d;

  always_comb begin
    if (ref_i == {1'b1, {(REF_W-1){1'b0}}})
      mag_abs = {ABS_W{1'b1}};
    else if (ref_i[REF_W-1])
      mag_abs = ABS_W'(-ref_i);
    else
      mag_abs = ABS_W'(ref_i);
    prod    = PROD_W'(mag_abs) * PROD_W'(half_i);
    mag     = prod[SHIFT +: MAG_W];
    half_x  = MAG_W'(half_i);
    neg_d   = ref_i[REF_W-1] || (ref_i == '0);
    outer_d = neg_d ? (mag >= half_x) : (mag > half_x);
    res_d   = outer_d ? (mag - half_x) : mag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o   <= '0;
      neg_o   <= 1'b1;
      outer_o <= 1'b0;
    end else begin
      res_o   <= res_d;
      neg_o   <= neg_d;
      outer_o <= outer_d;
    end
  end

  // R4: the residue never reaches past one carrier amplitude in the outer region
  a_r4_outer_residue: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $stable(half_i) && outer_o) |-> (res_o < MAG_W'(half_i)));

endmodule

// File: rtl/nlp_cell.sv
module nlp_cell
  import nlp_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [CNT_W:0]   res_i,
  input  logic             neg_i,
  input  logic             outer_i,
  input  logic [CNT_W-1:0] car_i,
  output lvl_t             lvl_d_o,
  output lvl_t             lvl_o,
  output gate_t            gate_o
);

  logic  hit;
  lvl_t  lvl_d;
  gate_t gate_d;

  always_comb begin
    hit = res_i > {1'b0, car_i};
    if (!en_i)
      lvl_d = '0;
    else if (!neg_i)
      lvl_d = outer_i ? (hit ? 3'sd2 : 3'sd1) : (hit ? 3'sd1 : 3'sd0);
    else
      lvl_d = outer_i ? (hit ? -3'sd2 : -3'sd1) : (hit ? -3'sd1 : 3'sd0);
    gate_d = lvl2gate(lvl_d, neg_i && en_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_o  <= '0;
      gate_o <= G_ZERO_P;
    end else begin
      lvl_o  <= lvl_d;
      gate_o <= gate_d;
    end
  end

  assign lvl_d_o = lvl_d;

  // R1: exactly two switches of the cell conduct
  a_r1_two_on: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($countones(gate_o) == 2));

  // R5: the level stays within the pair allowed for the region it was chosen in
  a_r5_region_pair: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(en_i)) |->
      ($past(neg_i)
        ? ($past(outer_i) ? (lvl_o == -3'sd2 || lvl_o == -3'sd1)
                          : (lvl_o == -3'sd1 || lvl_o == 3'sd0))
        : ($past(outer_i) ? (lvl_o == 3'sd2 || lvl_o == 3'sd1)
                          : (lvl_o == 3'sd1 || lvl_o == 3'sd0))));

  // R8: a disabled cycle parks the cell at zero with S3 and S4
  a_r8_parked: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(en_i)) |-> (lvl_o == 3'sd0 && gate_o == G_ZERO_P));

endmodule

// File: rtl/nine_level_pwm.sv
module nine_level_pwm
  import nlp_pkg::*;
#(
  parameter int REF_W   = 16,
  parameter int CNT_W   = 12,
  parameter int N_CELLS = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          en_i,
  input  logic                          ref_vld_i,
  input  logic [REF_W-1:0]              ref_i,
  input  logic [CNT_W-1:0]              car_half_i,
  output logic [N_CELLS*LVL_W-1:0]      cell_lvl_o,
  output logic [N_CELLS*GATE_W-1:0]     gate_o,
  output logic [$clog2(2*N_CELLS+1):0]  sum_o
);

  localparam int SUM_W = $clog2(2*N_CELLS+1) + 1;

  logic signed [REF_W-1:0] ref_q;
  logic [CNT_W:0]          res;
  logic                    neg, outer;
  lvl_t                    lvl_d [N_CELLS];
  lvl_t                    lvl_q [N_CELLS];
  logic signed [SUM_W-1:0] sum_d, sum_q;

  always_ff @(posedge clk) begin
    if (rst)            ref_q <= '0;
    else if (ref_vld_i) ref_q <= ref_i;
  end

  nlp_ref_scale #(.REF_W(REF_W), .CNT_W(CNT_W)) u_scale (
    .clk(clk), .rst(rst), .ref_i(ref_q), .half_i(car_half_i),
    .res_o(res), .neg_o(neg), .outer_o(outer)
  );

  for (genvar c = 0; c < N_CELLS; c++) begin : g_cell
    logic [CNT_W-1:0] car;
    gate_t            gate;

    nlp_carrier #(.CNT_W(CNT_W), .N_CELLS(N_CELLS), .IDX(c)) u_car (
      .clk(clk), .rst(rst), .half_i(car_half_i), .cnt_o(car)
    );

    nlp_cell #(.CNT_W(CNT_W)) u_cell (
      .clk(clk), .rst(rst), .en_i(en_i), .res_i(res), .neg_i(neg),
      .outer_i(outer), .car_i(car), .lvl_d_o(lvl_d[c]), .lvl_o(lvl_q[c]),
      .gate_o(gate)
    );

    assign cell_lvl_o[c*LVL_W +: LVL_W]   = lvl_q[c];
    assign gate_o[c*GATE_W +: GATE_W]     = gate;
  end

  always_comb begin
    sum_d = '0;
    for (int c = 0; c < N_CELLS; c++) sum_d = sum_d + SUM_W'(lvl_d[c]);
  end

  always_ff @(posedge clk) begin
    if (rst) sum_q <= '0;
    else     sum_q <= sum_d;
  end

  assign sum_o = sum_q;

  // checker-side total of the registered cell outputs
  logic signed [SUM_W-1:0] chk_sum;
  always_comb begin
    chk_sum = '0;
    for (int c = 0; c < N_CELLS; c++)
      chk_sum = chk_sum + SUM_W'($signed(cell_lvl_o[c*LVL_W +: LVL_W]));
  end

  // R7: reported sum matches the cell levels in the same cycle
  a_r7_sum_match: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($signed(sum_o) == chk_sum));

  // R3: the captured sample holds without a strobe
  a_r3_hold_sample: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ref_vld_i)) |-> $stable(ref_q));

endmodule

// File: tb/sim_nine_level_pwm.sv
`timescale 1ns/100ps
module sim_nine_level_pwm;

  localparam int NC   = 2;
  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en_i = 1'b1;
  logic        ref_vld_i = 1'b0;
  logic [15:0] ref_i = '0;
  logic [11:0] car_half_i = 12'(HALF);
  logic [5:0]  cell_lvl_o;
  logic [9:0]  gate_o;
  logic [3:0]  sum_o;

  int n_chk = 0, n_bad = 0, ecount = 0;
  bit done = 0;

  nine_level_pwm u0 (
    .clk(clk), .rst(rst), .en_i(en_i), .ref_vld_i(ref_vld_i), .ref_i(ref_i),
    .car_half_i(car_half_i), .cell_lvl_o(cell_lvl_o), .gate_o(gate_o), .sum_o(sum_o)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (rst) ecount <= 0;
    else     ecount <= ecount + 1;
  end

  function automatic int carrier_at(int k, int t);
    int p = (k * 2 * HALF / NC + t) % (2 * HALF);
    return (p <= HALF) ? p : 2 * HALF - p;
  endfunction

  function automatic int want_lvl(int r, int c);
    int a = (r < 0) ? -r : r;
    int m, res;
    bit outer;
    if (a > 32767) a = 32767;
    m = (a * HALF) >> 14;
    outer = (r > 0) ? (m > HALF) : (m >= HALF);
    res = outer ? m - HALF : m;
    if (r > 0) return outer ? ((res > c) ? 2 : 1) : ((res > c) ? 1 : 0);
    return outer ? ((res > c) ? -2 : -1) : ((res > c) ? -1 : 0);
  endfunction

  function automatic logic [4:0] want_gate(int l, bit neg);
    case (l)
      2:  return 5'b01001;
      1:  return 5'b11000;
      -1: return 5'b10010;
      -2: return 5'b00110;
      default: return neg ? 5'b00011 : 5'b01100;
    endcase
  endfunction

  function automatic int act_lvl(int k);
    return int'($signed(cell_lvl_o[3*k +: 3]));
  endfunction

  task automatic report(bit ok, string tag, int a0, int a1, int as, int e0, int e1, int es);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s edge %0d: act lvl %0d,%0d sum %0d gates %b; exp lvl %0d,%0d sum %0d",
               tag, ecount, a0, a1, as, gate_o, e0, e1, es);
    end
  endtask

  // exact comparison against the bench's own carrier timeline (R1 R2 R4 R5 R6 R7)
  task automatic check_window(int r, int ncyc, string tag);
    for (int i = 0; i < ncyc; i++) begin
      int e [NC];
      bit ok = 1;
      int es = 0;
      @(negedge clk);
      for (int k = 0; k < NC; k++) begin
        e[k] = want_lvl(r, carrier_at(k, ecount - 1));
        es += e[k];
        if (act_lvl(k) != e[k]) ok = 0;
        if (gate_o[5*k +: 5] != want_gate(e[k], r <= 0)) ok = 0;
      end
      if (int'($signed(sum_o)) != es) ok = 0;
      report(ok, tag, act_lvl(0), act_lvl(1), int'($signed(sum_o)), e[0], e[1], es);
    end
  endtask

  task automatic check_parked(int ncyc, string tag);
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      report(cell_lvl_o == '0 && sum_o == '0 && gate_o == {5'b01100, 5'b01100},
             tag, act_lvl(0), act_lvl(1), int'($signed(sum_o)), 0, 0, 0);
    end
  endtask

  task automatic strobe(int r);
    @(negedge clk);
    ref_i = 16'(r);
    ref_vld_i = 1'b1;
    @(negedge clk);
    ref_vld_i = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    report(cell_lvl_o == '0 && sum_o == '0 && gate_o == {5'b01100, 5'b01100},
           "R9 reset state", act_lvl(0), act_lvl(1), int'($signed(sum_o)), 0, 0, 0);
    rst = 1'b0;
  endtask

  // first strobe straight out of reset: exact carrier phases from edge 3 (R6, R3 latency)
  task automatic t_first_after_reset();
    ref_i = 16'(6000);
    ref_vld_i = 1'b1;
    @(negedge clk);
    ref_vld_i = 1'b0;
    @(negedge clk);
    check_window(6000, 4 * HALF, "R6 R3 phase after reset");
  endtask

  task automatic t_region(int r, string tag);
    strobe(r);
    check_window(r, 4 * HALF, tag);
  endtask

  task automatic t_hold();
    strobe(-9000);
    @(negedge clk);
    ref_i = 16'(20000);
    check_window(-9000, 3 * HALF, "R3 no strobe keeps sample");
  endtask

  task automatic t_enable();
    strobe(25000);
    @(negedge clk);
    en_i = 1'b0;
    check_parked(3 * HALF, "R8 disabled park");
    en_i = 1'b1;
    check_window(25000, 3 * HALF, "R8 resume on running carriers");
  endtask

  task automatic t_same_edge();
    strobe(30000);
    @(negedge clk);
    en_i = 1'b0;
    ref_i = 16'(-20000);
    ref_vld_i = 1'b1;
    @(negedge clk);
    ref_vld_i = 1'b0;
    report(cell_lvl_o == '0 && gate_o == {5'b01100, 5'b01100}, "R8 R2 same-edge park",
           act_lvl(0), act_lvl(1), int'($signed(sum_o)), 0, 0, 0);
    check_parked(5, "R8 parked after strobe");
    en_i = 1'b1;
    check_window(-20000, 3 * HALF, "R2 R5 negative after enable");
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: act not finished, exp finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_first_after_reset();
    t_region(3000,   "R5 positive inner");
    t_region(16384,  "R4 positive half boundary inner");
    t_region(27000,  "R5 positive outer");
    t_region(32767,  "R5 positive full scale");
    t_region(0,      "R2 zero reference S1S2");
    t_region(-5000,  "R5 negative inner");
    t_region(-16384, "R4 negative half boundary outer");
    t_region(-26000, "R5 negative outer");
    t_region(-32768, "R4 most negative saturates");
    t_hold();
    t_enable();
    t_same_edge();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule